// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the hardwired controller of a multicycle processor datapath that runs four instruction classes: word load, word store, register-to-register arithmetic and branch-on-equal. It is a Moore state machine. Every instruction starts with a fetch cycle, which reads the instruction and advances the program counter by four, and a decode cycle, which reads the registers and precomputes the branch target. The decode cycle then branches on the opcode into a short per-class tail. Every cycle the controller drives the full set of datapath control lines from its state. The only exception is the program-counter write in the branch state, which also depends on the ALU zero flag.

The control vector is held in a register next to the state register. It is computed from the next state, so the outputs change on the same edge as the state and have no decode logic after the flops. The current state is exported for observation. The surrounding datapath must hold the opcode stable from the decode cycle to the end of the instruction.

State codes on the `state` port: fetch=0, decode=1, address=2, mem-read=3, load-writeback=4, mem-write=5, R-execute=6, R-writeback=7, branch=8. ALU operation codes on `alu_op`: 00 add, 01 subtract, 10 use function field. Second-operand select codes on `alu_src_b`: 00 register B, 01 constant four, 10 sign-extended immediate, 11 shifted immediate. Opcodes: load 100011, store 101011, R-type 000000, branch-on-equal 000100.

Top module: `mc_ctl_top`

## Requirements
- R1: A synchronous active-high reset puts the state at fetch (code 0), with the fetch control vector, on the edge at which it is sampled, whatever the current state.
- R2: In fetch, pc_write=1, mem_read=1, ir_write=1, iord=0, alu_src_a=0, alu_src_b=01, alu_op=00, pc_source=0. The next state is decode.
- R3: In decode, alu_src_a=0, alu_src_b=11, alu_op=00 and all write and memory enables are 0. The next state is branch (8) for opcode 000100, R-execute (6) for 000000, and address (2) for 100011 or 101011.
- R4: In branch, alu_src_a=1, alu_src_b=00, alu_op=01, pc_source=1, and pc_write equals the zero input in the same cycle. The next state is fetch, so a branch takes 3 cycles.
- R5: R-execute drives alu_src_a=1, alu_src_b=00, alu_op=10. It is followed by R-writeback with reg_dst=1, mem_to_reg=0, reg_write=1, then fetch, for 4 cycles in total.
- R6: For a load (100011), address (alu_src_a=1, alu_src_b=10, alu_op=00) leads to mem-read (mem_read=1, iord=1), then load-writeback (reg_dst=0, mem_to_reg=1, reg_write=1), then fetch, for 5 cycles in total.
- R7: For a store (101011), address leads to mem-write (mem_write=1, iord=1), then fetch, for 4 cycles in total.
- R8: Any other opcode returns from decode straight to fetch, with no write or memory enable asserted, for 2 cycles in total.
- R9: Every control output not listed for a state is 0. In particular, the zero input has no effect on pc_write outside the branch state, and mem_read and mem_write are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field of the instruction register |
| zero | input | 1 | ALU zero flag |
| pc_write | output | 1 | Program counter write enable |
| iord | output | 1 | Memory address select: 0 PC, 1 ALU result |
| mem_read | output | 1 | Memory read enable |
| mem_write | output | 1 | Memory write enable |
| ir_write | output | 1 | Instruction register load |
| reg_dst | output | 1 | Destination register select: 1 rd field, 0 rt field |
| mem_to_reg | output | 1 | Register write data select: 1 memory data |
| reg_write | output | 1 | Register file write enable |
| alu_src_a | output | 1 | ALU A select: 0 PC, 1 register A |
| alu_src_b | output | 2 | ALU B select (codes above) |
| alu_op | output | 2 | ALU operation class (codes above) |
| pc_source | output | 1 | PC next value select: 0 ALU result, 1 ALU output register |
| state | output | 4 | Current state code |

## Verification
The bench builds the block with its default parameters: a 6-bit opcode field and the four opcode values listed above. With these values the four class tails can be reached by driving the four opcodes. Values outside that set, such as 001000 and 111111, reach the fall-back path to fetch. Within these settings the bench covers both zero polarities in the branch state and a zero flag held high through every other state. It also applies a reset in the middle of a load and runs instructions back to back, so that each tail is seen to hand over cleanly to the next fetch.

// File: rtl/mc_ctl_pkg.sv
package mc_ctl_pkg;
  localparam int STATE_W = 4;

  typedef enum logic [STATE_W-1:0] {
    S_FETCH  = 4'd0,
    S_DECODE = 4'd1,
    S_ADDR   = 4'd2,
    S_MEMRD  = 4'd3,
    S_LDWB   = 4'd4,
    S_MEMWR  = 4'd5,
    S_REXEC  = 4'd6,
    S_RWB    = 4'd7,
    S_BRANCH = 4'd8
  } state_e;

  localparam logic [1:0] ALU_ADD  = 2'b00;
  localparam logic [1:0] ALU_SUB  = 2'b01;
  localparam logic [1:0] ALU_FUNC = 2'b10;

  localparam logic [1:0] SRCB_REG   = 2'b00;
  localparam logic [1:0] SRCB_FOUR  = 2'b01;
  localparam logic [1:0] SRCB_IMM   = 2'b10;
  localparam logic [1:0] SRCB_SHIMM = 2'b11;

  typedef struct packed {
    logic       pc_write;
    logic       pc_branch;
    logic       iord;
    logic       mem_read;
    logic       mem_write;
    logic       ir_write;
    logic       reg_dst;
    logic       mem_to_reg;
    logic       reg_write;
    logic       alu_src_a;
    logic [1:0] alu_src_b;
    logic [1:0] alu_op;
    logic       pc_source;
  } ctrl_t;
endpackage

// File: rtl/mc_next_state.sv
module mc_next_state
  import mc_ctl_pkg::*;
#(
  parameter int OPW = 6,
  parameter logic [OPW-1:0] OP_LW  = 6'b100011,
  parameter logic [OPW-1:0] OP_SW  = 6'b101011,
  parameter logic [OPW-1:0] OP_RT  = 6'b000000,
  parameter logic [OPW-1:0] OP_BEQ = 6'b000100
) (
  input  state_e         cur,
  input  logic [OPW-1:0] opcode,
  output state_e         nxt
);
  always_comb begin
    nxt = S_FETCH;
    unique case (cur)
      S_FETCH:  nxt = S_DECODE;
      S_DECODE: begin
        if (opcode == OP_BEQ)                         nxt = S_BRANCH;
        else if (opcode == OP_RT)                     nxt = S_REXEC;
        else if (opcode == OP_LW || opcode == OP_SW)  nxt = S_ADDR;
        else                                          nxt = S_FETCH;
      end
      S_ADDR:   nxt = (opcode == OP_SW) ? S_MEMWR : S_MEMRD;
      S_MEMRD:  nxt = S_LDWB;
      S_REXEC:  nxt = S_RWB;
      default:  nxt = S_FETCH;
    endcase
  end
endmodule

// File: rtl/mc_ctl_decode.sv
module mc_ctl_decode
  import mc_ctl_pkg::*;
(
  input  state_e st,
  output ctrl_t  c
);
  always_comb begin
    c = '0;
    unique case (st)
      S_FETCH: begin
        c.pc_write  = 1'b1;
        c.mem_read  = 1'b1;
        c.ir_write  = 1'b1;
        c.alu_src_b = SRCB_FOUR;
        c.alu_op    = ALU_ADD;
      end
      S_DECODE: begin
        c.alu_src_b = SRCB_SHIMM;
        c.alu_op    = ALU_ADD;
      end
      S_ADDR: begin
        c.alu_src_a = 1'b1;
        c.alu_src_b = SRCB_IMM;
        c.alu_op    = ALU_ADD;
      end
      S_MEMRD: begin
        c.mem_read = 1'b1;
        c.iord     = 1'b1;
      end
      S_LDWB: begin
        c.mem_to_reg = 1'b1;
        c.reg_write  = 1'b1;
      end
      S_MEMWR: begin
        c.mem_write = 1'b1;
        c.iord      = 1'b1;
      end
      S_REXEC: begin
        c.alu_src_a = 1'b1;
        c.alu_src_b = SRCB_REG;
        c.alu_op    = ALU_FUNC;
      end
      S_RWB: begin
        c.reg_dst   = 1'b1;
        c.reg_write = 1'b1;
      end
      S_BRANCH: begin
        c.pc_branch = 1'b1;
        c.alu_src_a = 1'b1;
        c.alu_src_b = SRCB_REG;
        c.alu_op    = ALU_SUB;
        c.pc_source = 1'b1;
      end
      default: c = '0;
    endcase
  end
endmodule

// File: rtl/mc_ctl_top.sv
module mc_ctl_top
  import mc_ctl_pkg::*;
#(
  parameter int OPW = 6,
  parameter logic [OPW-1:0] OP_LW  = 6'b100011,
  parameter logic [OPW-1:0] OP_SW  = 6'b101011,
  parameter logic [OPW-1:0] OP_RT  = 6'b000000,
  parameter logic [OPW-1:0] OP_BEQ = 6'b000100
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [OPW-1:0]     opcode,
  input  logic               zero,
  output logic               pc_write,
  output logic               iord,
  output logic               mem_read,
  output logic               mem_write,
  output logic               ir_write,
  output logic               reg_dst,
  output logic               mem_to_reg,
  output logic               reg_write,
  output logic               alu_src_a,
  output logic [1:0]         alu_src_b,
  output logic [1:0]         alu_op,
  output logic               pc_source,
  output logic [STATE_W-1:0] state
);
  state_e state_q, state_d, state_sel;
  ctrl_t  ctrl_q, ctrl_d;

  mc_next_state #(
    .OPW(OPW), .OP_LW(OP_LW), .OP_SW(OP_SW), .OP_RT(OP_RT), .OP_BEQ(OP_BEQ)
  ) u_next (
    .cur(state_q), .opcode(opcode), .nxt(state_d)
  );

  assign state_sel = rst ? S_FETCH : state_d;

  mc_ctl_decode u_dec (.st(state_sel), .c(ctrl_d));

  always_ff @(posedge clk) begin
    state_q <= state_sel;
    ctrl_q  <= ctrl_d;
  end

  assign pc_write   = ctrl_q.pc_write | (ctrl_q.pc_branch & zero);
  assign iord       = ctrl_q.iord;
  assign mem_read   = ctrl_q.mem_read;
  assign mem_write  = ctrl_q.mem_write;
  assign ir_write   = ctrl_q.ir_write;
  assign reg_dst    = ctrl_q.reg_dst;
  assign mem_to_reg = ctrl_q.mem_to_reg;
  assign reg_write  = ctrl_q.reg_write;
  assign alu_src_a  = ctrl_q.alu_src_a;
  assign alu_src_b  = ctrl_q.alu_src_b;
  assign alu_op     = ctrl_q.alu_op;
  assign pc_source  = ctrl_q.pc_source;
  assign state      = state_q;

  assert_rst_fetch_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (state_q == S_FETCH && ir_write));

  assert_fetch_vec_R2: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_FETCH) |-> (pc_write && mem_read && ir_write && !iord
                              && alu_src_b == SRCB_FOUR));

  assert_decode_beq_R3: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_DECODE && opcode == OP_BEQ) |=> (state_q == S_BRANCH));

  assert_branch_pcw_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_BRANCH) |-> (pc_write == zero));

  assert_rtype_wb_R5: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_RWB) |-> ($past(state_q) == S_REXEC && reg_write && reg_dst));

  assert_load_wb_R6: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_LDWB) |-> ($past(state_q) == S_MEMRD && reg_write && mem_to_reg));

  assert_store_ret_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_MEMWR) |=> (state_q == S_FETCH));

  assert_unknown_op_R8: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_DECODE && opcode != OP_BEQ && opcode != OP_RT
     && opcode != OP_LW && opcode != OP_SW) |=> (state_q == S_FETCH));

  assert_mem_excl_R9: assert property (@(posedge clk) disable iff (rst)
    !(mem_read && mem_write));

  assert_pcw_gate_R9: assert property (@(posedge clk) disable iff (rst)
    (state_q != S_FETCH && state_q != S_BRANCH) |-> !pc_write);
endmodule

// File: tb/sim_mc_ctl_top.sv
module sim_mc_ctl_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'b0;
  logic       zero = 1'b0;
  logic       pc_write, iord, mem_read, mem_write, ir_write, reg_dst;
  logic       mem_to_reg, reg_write, alu_src_a, pc_source;
  logic [1:0] alu_src_b, alu_op;
  logic [3:0] state;

  always #2.5 clk = ~clk;

  mc_ctl_top u0 (
    .clk(clk), .rst(rst), .opcode(opcode), .zero(zero),
    .pc_write(pc_write), .iord(iord), .mem_read(mem_read), .mem_write(mem_write),
    .ir_write(ir_write), .reg_dst(reg_dst), .mem_to_reg(mem_to_reg),
    .reg_write(reg_write), .alu_src_a(alu_src_a), .alu_src_b(alu_src_b),
    .alu_op(alu_op), .pc_source(pc_source), .state(state)
  );

  int checks = 0;
  int fails  = 0;
  logic [17:0] exp_q[$];
  string       tag_q[$];

  // vector: {state, pcw, iord, mrd, mwr, irw, rdst, m2r, rw, srca, srcb, aop, pcs}
  function automatic logic [17:0] expv(input int st, input logic z);
    logic [3:0] s;
    s = st[3:0];
    case (st)
      0: return {s, 8'b1010_1000, 1'b0, 2'b01, 2'b00, 1'b0};
      1: return {s, 8'b0000_0000, 1'b0, 2'b11, 2'b00, 1'b0};
      2: return {s, 8'b0000_0000, 1'b1, 2'b10, 2'b00, 1'b0};
      3: return {s, 8'b0110_0000, 1'b0, 2'b00, 2'b00, 1'b0};
      4: return {s, 8'b0000_0011, 1'b0, 2'b00, 2'b00, 1'b0};
      5: return {s, 8'b0101_0000, 1'b0, 2'b00, 2'b00, 1'b0};
      6: return {s, 8'b0000_0000, 1'b1, 2'b00, 2'b10, 1'b0};
      7: return {s, 8'b0000_0101, 1'b0, 2'b00, 2'b00, 1'b0};
      8: return {s, z, 7'b000_0000, 1'b1, 2'b00, 2'b01, 1'b1};
      default: return '0;
    endcase
  endfunction

  task automatic push(input int st, input string tag);
    exp_q.push_back(expv(st, zero));
    tag_q.push_back(tag);
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic run_instr(input logic [5:0] op, input logic z, input string tag);
    int seq[$];
    opcode = op;
    zero   = z;
    case (op)
      6'b100011: seq = '{0, 1, 2, 3, 4};
      6'b101011: seq = '{0, 1, 2, 5};
      6'b000000: seq = '{0, 1, 6, 7};
      6'b000100: seq = '{0, 1, 8};
      default:   seq = '{0, 1};
    endcase
    foreach (seq[i]) begin
      push(seq[i], tag);
      step();
    end
  endtask

  always @(negedge clk) begin
    if (exp_q.size() != 0) begin
      logic [17:0] e, a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {state, pc_write, iord, mem_read, mem_write, ir_write, reg_dst,
           mem_to_reg, reg_write, alu_src_a, alu_src_b, alu_op, pc_source};
      checks++;
      if (a !== e) begin
        fails++;
        $display("FAIL %s actual=%b expected=%b", t, a, e);
      end
    end
  end

  bit finished = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    #1;
    step();
    push(0, "R1 reset");
    step();
    rst = 1'b0;
    run_instr(6'b100011, 1'b0, "R6 load");
    run_instr(6'b101011, 1'b1, "R7 store");
    run_instr(6'b000000, 1'b1, "R5 rtype, R9 zero ignored");
    run_instr(6'b000100, 1'b1, "R4 beq taken");
    run_instr(6'b000100, 1'b0, "R4 beq not taken");
    run_instr(6'b001000, 1'b1, "R8 unknown op");
    run_instr(6'b111111, 1'b0, "R8 unknown op");
    // R1: reset taken from the middle of a load
    opcode = 6'b100011;
    zero   = 1'b0;
    push(0, "R2 fetch"); step();
    push(1, "R3 decode"); step();
    push(2, "R6 addr"); rst = 1'b1; step();
    push(0, "R1 mid reset"); step();
    rst = 1'b0;
    run_instr(6'b000100, 1'b0, "R4 beq after reset");
    run_instr(6'b100011, 1'b1, "R6 load zero high");
    run_instr(6'b000000, 1'b0, "R5 rtype");
    run_instr(6'b101011, 1'b0, "R7 store");
    @(negedge clk);
    @(negedge clk);
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R9 scoreboard actual=%0d expected=0", exp_q.size());
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule